// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits in the command path of a double-data-rate memory device. It holds a seven-bit mode word that sets the burst length, the wrap order inside a burst and the read latency. It turns each accepted read or write command into the stream of column addresses for that burst, one address per data beat. Each burst stays inside an aligned group of columns whose size equals the burst length. The start column picks the first column in the group, and the programmed order decides how the rest follow.

Commands arrive on a valid/ready channel. A command transfers on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a burst is still being emitted and while the settle window after a mode change runs. A producer that sees `cmd_ready` low must hold its command until it is taken.

Column addresses leave on a second valid/ready channel. A beat transfers on an edge where `col_valid` and `col_ready` are both high. While `col_ready` is low, the current address and its flags stay exactly as they are. The decoded burst length and read latency, the error pulse and the busy flag are plain status pins.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `burst_len` is 4, `cas_lat` is 3, the order is sequential, `busy`, `mode_err` and `col_valid` are 0, and `cmd_ready` is 1.
- R2: A mode-set command uses op code 01. When it is accepted with `cmd_ba`=00, `all_idle`=1 and legal codes, it loads `cmd_addr[2:0]` as the length code, `cmd_addr[3]` as the order and `cmd_addr[6:4]` as the latency code. The new values show on `burst_len` and `cas_lat` from the cycle after acceptance. Length codes are 001=2, 010=4, 011=8 and 100=16. Order 0 is sequential and order 1 is interleaved. Latency codes are 010=2 and 011=3.
- R3: A mode-set with `cmd_ba`≠00, or a no-op command (op 00), leaves the mode word unchanged, raises no error and starts no busy window.
- R4: A mode-set with `cmd_ba`=00 that carries a reserved length or latency code sets `mode_err` high for exactly the one cycle after acceptance. The mode word keeps its previous value and `busy` stays low.
- R5: A mode-set with `cmd_ba`=00 accepted while `all_idle` is 0 is refused in the same way as R4, even if its codes are legal.
- R6: After an applied mode-set, `busy` is high for exactly MRD_CYCLES cycles, starting the cycle after acceptance. `cmd_ready` is low during that window.
- R7: A read (op 10) or a write (op 11) with start column S produces exactly BL beats. `col_valid` goes high from the cycle after acceptance. Column bits at and above log2(BL) equal those of S on every beat. `col_last` marks only the final beat, and `col_is_write` is 1 for writes. The same length applies to reads and writes.
- R8: In sequential order, the low log2(BL) bits of beat i are (S + i) mod BL.
- R9: In interleaved order, the low log2(BL) bits of beat i are S XOR i.
- R10: While `col_valid` is high and `col_ready` is low, `col_addr`, `col_last` and `col_valid` hold. `cmd_ready` stays low from acceptance of a burst until the cycle after its last beat transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 00 no-op, 01 mode-set, 10 read, 11 write |
| cmd_ba | input | 2 | Bank-select bits; a mode-set acts only when 00 |
| cmd_addr | input | COL_W | Mode word in bits [6:0], or start column |
| all_idle | input | 1 | All banks idle |
| col_valid | output | 1 | Column address beat offered |
| col_ready | input | 1 | Consumer takes the beat |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Final beat of the burst |
| col_is_write | output | 1 | Burst belongs to a write command |
| burst_len | output | 5 | Decoded burst length (2, 4, 8 or 16) |
| cas_lat | output | 2 | Decoded read latency (2 or 3) |
| mode_err | output | 1 | One-cycle pulse for a refused mode-set |
| busy | output | 1 | Settle window after a mode change |

## Verification
The embedded properties rely on only two things outside the block. First, `all_idle` is a meaningful level on the edge where a mode-set transfers. Second, `col_ready` may toggle freely at any cycle. The bench changes every input only on the falling clock edge. It holds each command steady until it sees `cmd_ready` high, and it uses only the four two-bit op codes. It sweeps every length and latency code in both orders, and all sixteen low start positions for each legal length. It also drives a repeating `col_ready` stall pattern on half of the bursts, so the hold and wrap properties see both steady and stalled flow.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int unsigned MAX_BEAT_W = 4;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_MODE  = 2'b01,
    OP_READ  = 2'b10,
    OP_WRITE = 2'b11
  } bcs_op_e;

  typedef struct packed {
    logic [2:0] lat_code;
    logic       interleave;
    logic [2:0] len_code;
  } mode_word_t;

  localparam mode_word_t MODE_RESET = '{lat_code: 3'b011, interleave: 1'b0, len_code: 3'b010};

  function automatic logic len_code_ok(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3) || (code == 3'd4);
  endfunction

  function automatic logic lat_code_ok(input logic [2:0] code);
    return (code == 3'd2) || (code == 3'd3);
  endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import burst_col_pkg::*;
#(
  parameter int unsigned MRD_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_fire,
  input  logic [1:0] set_ba,
  input  mode_word_t set_word,
  input  logic       all_idle,
  output logic [2:0] len_log2,
  output logic       interleave,
  output logic [1:0] cas_lat,
  output logic       mode_err,
  output logic       busy
);
  localparam int unsigned CNT_W = $clog2(MRD_CYCLES + 1);

  mode_word_t       mode_q;
  logic             err_q;
  logic [CNT_W-1:0] cnt_q;
  logic             addressed;
  logic             legal;

  always_comb begin
    addressed = set_fire && (set_ba == 2'b00);
    legal     = len_code_ok(set_word.len_code) && lat_code_ok(set_word.lat_code) && all_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      err_q <= addressed && !legal;
      if (addressed && legal) begin
        mode_q <= set_word;
        cnt_q  <= CNT_W'(MRD_CYCLES);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign len_log2   = mode_q.len_code;
  assign interleave = mode_q.interleave;
  assign cas_lat    = mode_q.lat_code[1:0];
  assign mode_err   = err_q;
  assign busy       = (cnt_q != '0);

  assert_refused_keeps_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> ($stable(mode_q) && !busy));

  assert_load_needs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(all_idle && set_fire && set_ba == 2'b00));

  assert_codes_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    len_code_ok(mode_q.len_code) && lat_code_ok(mode_q.lat_code));

  assert_busy_starts_on_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(set_fire && set_ba == 2'b00));

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_fire,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_write,
  input  logic [2:0]       len_log2,
  input  logic             interleave,
  input  logic             col_ready,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             col_is_write
);
  localparam int unsigned BEAT_W = MAX_BEAT_W;

  logic              active_q;
  logic [COL_W-1:0]  base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [2:0]        log_q;
  logic              ilv_q;
  logic              wr_q;
  logic [COL_W-1:0]  mask;
  logic [COL_W-1:0]  beat_ext;
  logic [COL_W-1:0]  low;

  always_comb begin
    mask     = (COL_W'(1) << log_q) - COL_W'(1);
    beat_ext = COL_W'(beat_q);
    low      = ilv_q ? (base_q ^ beat_ext) : (base_q + beat_ext);
    col_addr = (base_q & ~mask) | (low & mask);
    col_last = active_q && (beat_ext == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      log_q    <= 3'd1;
      ilv_q    <= 1'b0;
      wr_q     <= 1'b0;
    end else if (start_fire) begin
      active_q <= 1'b1;
      base_q   <= start_col;
      beat_q   <= '0;
      log_q    <= len_log2;
      ilv_q    <= interleave;
      wr_q     <= start_write;
    end else if (active_q && col_ready) begin
      if (col_last) active_q <= 1'b0;
      else          beat_q   <= beat_q + 1'b1;
    end
  end

  assign col_valid    = active_q;
  assign col_is_write = wr_q;

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready) |=> (col_valid && $stable(col_addr) && $stable(col_last)));

  assert_block_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && !col_last) |=> (col_valid && (((col_addr ^ $past(col_addr)) & ~mask) == '0)));

  assert_seq_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && !col_last && !ilv_q) |=> (((col_addr - $past(col_addr)) & mask) == COL_W'(1)));

  assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && col_last) |=> !col_valid);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W      = 10,
  parameter int unsigned MRD_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [1:0]       cmd_ba,
  input  logic [COL_W-1:0] cmd_addr,
  input  logic             all_idle,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             col_is_write,
  output logic [4:0]       burst_len,
  output logic [1:0]       cas_lat,
  output logic             mode_err,
  output logic             busy
);
  localparam int unsigned MODE_W = $bits(mode_word_t);

  logic       cmd_fire;
  logic       set_fire;
  logic       start_fire;
  logic [2:0] len_log2;
  logic       interleave;
  mode_word_t set_word;

  always_comb begin
    cmd_ready  = !busy && !col_valid;
    cmd_fire   = cmd_valid && cmd_ready;
    set_fire   = cmd_fire && (bcs_op_e'(cmd_op) == OP_MODE);
    start_fire = cmd_fire && ((bcs_op_e'(cmd_op) == OP_READ) || (bcs_op_e'(cmd_op) == OP_WRITE));
    set_word   = mode_word_t'(cmd_addr[MODE_W-1:0]);
    burst_len  = 5'd1 << len_log2;
  end

  bcs_mode_reg #(.MRD_CYCLES(MRD_CYCLES)) mode_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_fire   (set_fire),
    .set_ba     (cmd_ba),
    .set_word   (set_word),
    .all_idle   (all_idle),
    .len_log2   (len_log2),
    .interleave (interleave),
    .cas_lat    (cas_lat),
    .mode_err   (mode_err),
    .busy       (busy)
  );

  bcs_addr_gen #(.COL_W(COL_W)) gen_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_fire   (start_fire),
    .start_col    (cmd_addr),
    .start_write  (cmd_op[0]),
    .len_log2     (len_log2),
    .interleave   (interleave),
    .col_ready    (col_ready),
    .col_valid    (col_valid),
    .col_addr     (col_addr),
    .col_last     (col_last),
    .col_is_write (col_is_write)
  );

  assert_mode_frozen_in_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && $past(col_valid)) |-> ($stable(burst_len) && $stable(cas_lat)));

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 10;
  localparam int MRD        = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [1:0]       cmd_op = 2'b00;
  logic [1:0]       cmd_ba = 2'b00;
  logic [COL_W-1:0] cmd_addr = '0;
  logic             all_idle = 1'b1;
  logic             col_valid;
  logic             col_ready = 1'b1;
  logic [COL_W-1:0] col_addr;
  logic             col_last;
  logic             col_is_write;
  logic [4:0]       burst_len;
  logic [1:0]       cas_lat;
  logic             mode_err;
  logic             busy;

  int n_chk = 0;
  int n_err = 0;
  int exp_log = 2;
  int exp_ilv = 0;
  int exp_cl  = 3;
  int stall_seq = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W), .MRD_CYCLES(MRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .all_idle(all_idle),
    .col_valid(col_valid), .col_ready(col_ready), .col_addr(col_addr),
    .col_last(col_last), .col_is_write(col_is_write), .burst_len(burst_len),
    .cas_lat(cas_lat), .mode_err(mode_err), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [1:0] ba, input logic [COL_W-1:0] addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ba = ba; cmd_addr = addr;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_status(input string req);
    chk(burst_len == 5'(1 << exp_log), req, "burst_len", burst_len, 1 << exp_log);
    chk(cas_lat == 2'(exp_cl), req, "cas_lat", cas_lat, exp_cl);
  endtask

  task automatic mode_set(input int lc, input int bt, input int cc, input int ba, input bit idle);
    bit addressed, legal;
    string req;
    int n;
    addressed = (ba == 0);
    legal = (lc >= 1 && lc <= 4) && (cc == 2 || cc == 3) && idle;
    if (!addressed) req = "R3";
    else if (!idle) req = "R5";
    else if (!legal) req = "R4";
    else req = "R2";
    all_idle = idle;
    do_cmd(2'b01, 2'(ba), {3'(lc * 5 + cc), 3'(cc), 1'(bt), 3'(lc)});
    all_idle = 1'b1;
    if (addressed && legal) begin
      exp_log = lc; exp_ilv = bt; exp_cl = cc;
    end
    chk(mode_err == (addressed && !legal), req, "mode_err pulse", mode_err, addressed && !legal);
    check_status(req);
    if (addressed && legal) begin
      n = 0;
      while (busy && n < 50) begin
        chk(!cmd_ready, "R6", "cmd_ready in busy", cmd_ready, 0);
        n++;
        @(negedge clk);
      end
      chk(n == MRD, "R6", "busy length", n, MRD);
    end else begin
      chk(!busy, req, "busy after refused", busy, 0);
      @(negedge clk);
      chk(!mode_err, req, "mode_err one cycle", mode_err, 0);
    end
  endtask

  task automatic run_burst(input bit wr, input int start, input bit bp);
    int bl, i, guard, ex;
    bit rdy, prev_stall;
    bl = 1 << exp_log;
    do_cmd(wr ? 2'b11 : 2'b10, 2'b00, COL_W'(start));
    i = 0; guard = 0; prev_stall = 1'b0;
    while (i < bl && guard < 200) begin
      if (exp_ilv != 0) ex = (start & ~(bl - 1)) | ((start ^ i) & (bl - 1));
      else              ex = (start & ~(bl - 1)) | ((start + i) & (bl - 1));
      ex = ex & ((1 << COL_W) - 1);
      chk(col_valid && !cmd_ready, "R7", "valid during burst", col_valid, 1);
      chk(int'(col_addr) == ex, prev_stall ? "R10" : (exp_ilv != 0 ? "R9" : "R8"), "col_addr", col_addr, ex);
      chk(col_last == (i == bl - 1) && col_is_write == wr, "R7", "last/write flags",
          {col_last, col_is_write}, {(i == bl - 1), wr});
      rdy = bp ? (stall_seq % 3 != 2) : 1'b1;
      stall_seq++;
      col_ready = rdy;
      @(negedge clk);
      if (rdy) i++;
      prev_stall = !rdy;
      guard++;
    end
    col_ready = 1'b1;
    chk(!col_valid && cmd_ready, "R10", "idle after last beat", {col_valid, cmd_ready}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(burst_len == 5'd4 && cas_lat == 2'd3, "R1", "reset mode", {burst_len, cas_lat}, {5'd4, 2'd3});
    chk(!busy && !mode_err && !col_valid && cmd_ready, "R1", "reset flags",
        {busy, mode_err, col_valid, cmd_ready}, 1);
    run_burst(1'b0, 10'h2B6, 1'b0);
    run_burst(1'b1, 10'h0F3, 1'b1);

    for (int lc = 0; lc < 8; lc++)
      for (int cc = 0; cc < 8; cc++)
        for (int bt = 0; bt < 2; bt++)
          mode_set(lc, bt, cc, 0, 1'b1);

    mode_set(2, 0, 2, 0, 1'b0);
    for (int ba = 1; ba < 4; ba++) mode_set(1, 0, 2, ba, 1'b1);
    run_burst(1'b0, 10'h155, 1'b0);
    do_cmd(2'b00, 2'b00, 10'h3FF);
    chk(!col_valid && !busy && !mode_err, "R3", "no-op ignored", {col_valid, busy, mode_err}, 0);
    check_status("R3");

    for (int lg = 1; lg <= 4; lg++)
      for (int bt = 0; bt < 2; bt++) begin
        mode_set(lg, bt, 2 + (lg % 2), 0, 1'b1);
        for (int s = 0; s < 16; s++)
          run_burst(1'(s), s | (((s * 37 + lg * 5) & 63) << 4), 1'(s >> 1));
      end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule